// File: doc/BRIEF.md
# GPIO Port with Level Interrupt Controller

This block is a general-purpose I/O port, 32 pins wide by default, with a small interrupt controller behind it. Software reaches it over a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. The address space is split into two windows. The port window sets the pin directions, drives output values, reads back pin levels and selects a level polarity for each pin. It also holds the latched interrupt status. The controller window shows the pending sources and holds a mask.

Every pin input passes through a two-flop synchroniser. The synchronised level is compared with the polarity bit of its pin. While the two match, the status bit of that pin is set. The bit stays set after the level goes away, and it clears only when software writes a zero to it. There is no edge detection. Pending is a read-only view of status. A single interrupt request goes to a parent controller. It is raised when any pending source is not masked. The mask resets to all ones, so no source can interrupt until software opens it.

Top module: `gpio_lvl_irq`

## Requirements
- R1: While reset is held, the registers read as follows: direction, data, polarity and status all read 0 and the mask reads all ones. During reset pin_oe is 0 and irq_out is 0.
- R2: Address bit 4 selects the window: 0 is the port window and 1 is the controller window. Address bits 1:0 must be 0. Port window offsets are 0x00 direction, 0x04 data, 0x08 polarity and 0x0C status. Controller window offsets are 0x00 pending and 0x08 mask. Any other address, including a misaligned one, reads 0.
- R3: pin_oe equals the direction register, where 1 means output. pin_out equals the data register.
- R4: Reading data returns the data register bit for output pins and the synchronised pin level for input pins.
- R5: A change on pin_in becomes visible in the data readback after exactly two rising clock edges, not after one.
- R6: A status bit becomes 1 on the edge after the synchronised level equals its polarity bit (polarity 1 means active high, 0 means active low). The bit stays 1 after the level turns inactive.
- R7: A write to status clears, on that edge, every bit written as 0. Bits written as 1 keep their value. If the level is still active, the cleared bit is set again on the following edge.
- R8: Reading pending returns the status register. Writes to pending change no register.
- R9: irq_out is 1 exactly when some bit has status 1 and mask 0. Writing all ones to the mask forces irq_out to 0.
- R10: Writes to addresses that decode to nothing change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address; bit 4 picks the window |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| pin_in | input | W | Asynchronous pin levels |
| pin_out | output | W | Output drive values |
| pin_oe | output | W | Output enables |
| irq_out | output | 1 | Combined interrupt request to the parent |

## Verification
The bench builds the block at its default width of 32 pins. At that width the all-ones mask and the top bit are exercised, and a full word of ack-by-zero patterns can be written. A directed phase covers the reset values, the two-edge synchroniser delay, a re-set after an ack while the level is still held, and latching after the level drops. A random phase then writes every address, including misaligned and unmapped ones, while the pin levels change. Throughout both phases a behavioural model is compared with the outputs and reads on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned BUS_ADDR_W = 5;
    localparam int unsigned WIN_BIT    = BUS_ADDR_W - 1;

    localparam logic [1:0] WORD_DIR  = 2'd0;
    localparam logic [1:0] WORD_DATA = 2'd1;
    localparam logic [1:0] WORD_POL  = 2'd2;
    localparam logic [1:0] WORD_STAT = 2'd3;
    localparam logic [1:0] WORD_PEND = 2'd0;
    localparam logic [1:0] WORD_MASK = 2'd2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_DATA,
        SEL_POL,
        SEL_STAT,
        SEL_PEND,
        SEL_MASK
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
    } bus_access_t;

    function automatic reg_sel_e decode_sel(input logic [BUS_ADDR_W-1:0] addr);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (!addr[WIN_BIT]) begin
                case (addr[3:2])
                    WORD_DIR:  sel = SEL_DIR;
                    WORD_DATA: sel = SEL_DATA;
                    WORD_POL:  sel = SEL_POL;
                    default:   sel = SEL_STAT;
                endcase
            end else begin
                if (addr[3:2] == WORD_PEND)      sel = SEL_PEND;
                else if (addr[3:2] == WORD_MASK) sel = SEL_MASK;
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= '0;
                    else     chain_q[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_access_t  acc,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_lvl,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] stat_q
);
    logic         stat_wr;
    logic [W-1:0] active;
    logic [W-1:0] ack_clr;

    assign stat_wr = acc.wr && (acc.sel == SEL_STAT);
    assign ack_clr = stat_wr ? ~wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
            pol_q  <= '0;
        end else if (acc.wr) begin
            if (acc.sel == SEL_DIR)  dir_q  <= wdata;
            if (acc.sel == SEL_DATA) data_q <= wdata;
            if (acc.sel == SEL_POL)  pol_q  <= wdata;
        end
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_stat
            assign active[i] = ~(pin_lvl[i] ^ pol_q[i]);
            always_ff @(posedge clk) begin
                if (rst)             stat_q[i] <= 1'b0;
                else if (ack_clr[i]) stat_q[i] <= 1'b0;
                else                 stat_q[i] <= stat_q[i] | active[i];
            end
        end
    endgenerate

    // R7: bits acknowledged with a zero read 0 on the next cycle
    assert_stat_ack_R7: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((stat_q & ~$past(wdata)) == '0));

    // R6: without an ack, set bits stay set
    assert_stat_latch_R6: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6: an active level sets its bit unless acknowledged
    assert_stat_set_R6: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((stat_q & $past(active)) == $past(active)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_access_t  acc,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pend,
    output logic [W-1:0] mask_q,
    output logic         irq_out
);
    logic [W-1:0] live;

    always_ff @(posedge clk) begin
        if (rst)                                mask_q <= '1;
        else if (acc.wr && acc.sel == SEL_MASK) mask_q <= wdata;
    end

    assign live    = pend & ~mask_q;
    assign irq_out = |live;

    // R1: every source is masked when reset lets go
    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1));
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          bus_rdata,
    input  logic [W-1:0]          pin_in,
    output logic [W-1:0]          pin_out,
    output logic [W-1:0]          pin_oe,
    output logic                  irq_out
);
    bus_access_t  acc;
    logic [W-1:0] pin_lvl;
    logic [W-1:0] dir_q, data_q, pol_q, stat_q, mask_q;

    assign acc.sel = decode_sel(bus_addr);
    assign acc.wr  = bus_wr;

    gpio_pin_sync #(.W(W), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .pin_sync  (pin_lvl)
    );

    gpio_port_regs #(.W(W)) u_port (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wdata   (bus_wdata),
        .pin_lvl (pin_lvl),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .pol_q   (pol_q),
        .stat_q  (stat_q)
    );

    gpio_irq_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wdata   (bus_wdata),
        .pend    (stat_q),
        .mask_q  (mask_q),
        .irq_out (irq_out)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    always_comb begin
        case (acc.sel)
            SEL_DIR:  bus_rdata = dir_q;
            SEL_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_lvl);
            SEL_POL:  bus_rdata = pol_q;
            SEL_STAT: bus_rdata = stat_q;
            SEL_PEND: bus_rdata = stat_q;
            SEL_MASK: bus_rdata = mask_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R9: a fully closed mask silences the request
    assert_irq_closed_R9: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq_out);
endmodule

// File: tb/gpio_lvl_irq_test.sv
module gpio_lvl_irq_test;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_out, pin_oe;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit live = 0;

    always #10 clk = ~clk;

    gpio_lvl_irq #(.W(W)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // behavioural reference
    logic [W-1:0] m_s1, m_s2, m_dir, m_data, m_pol, m_stat, m_mask;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_dir <= '0; m_data <= '0;
            m_pol <= '0; m_stat <= '0; m_mask <= '1;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (bus_wr && bus_addr == 5'h00) m_dir  <= bus_wdata;
            if (bus_wr && bus_addr == 5'h04) m_data <= bus_wdata;
            if (bus_wr && bus_addr == 5'h08) m_pol  <= bus_wdata;
            if (bus_wr && bus_addr == 5'h18) m_mask <= bus_wdata;
            for (int i = 0; i < W; i++) begin
                if (bus_wr && bus_addr == 5'h0C && !bus_wdata[i]) m_stat[i] <= 1'b0;
                else if (m_s2[i] == m_pol[i])                    m_stat[i] <= 1'b1;
            end
        end
        live <= 1'b1;
    end

    function automatic logic [W-1:0] model_read(input logic [4:0] a);
        case (a)
            5'h00: return m_dir;
            5'h04: return (m_dir & m_data) | (~m_dir & m_s2);
            5'h08: return m_pol;
            5'h0C: return m_stat;
            5'h10: return m_stat;
            5'h18: return m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            check("R3 pin_out", pin_out, m_data);
            check("R3 pin_oe", pin_oe, m_dir);
            check("R9 irq_out", {31'b0, irq_out}, {31'b0, |(m_stat & ~m_mask)});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a);
        bus_addr = a; #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic rd_lit(input string tag, input logic [4:0] a, input logic [W-1:0] exp);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        tick(3);
        // R1: reset values, read while reset is held
        rd_lit("R1 dir", 5'h00, '0);
        rd_lit("R1 pol", 5'h08, '0);
        rd_lit("R1 stat", 5'h0C, '0);
        rd_lit("R1 mask", 5'h18, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq_out}, '0);
        check("R1 oe", pin_oe, '0);
        rst = 1'b0;
        tick(1);

        // R5: two-edge synchroniser delay
        pin_in = 32'hA5A5_0F0F;
        tick(1);
        rd_lit("R5 one edge", 5'h04, '0);
        tick(1);
        rd_lit("R5 two edges", 5'h04, 32'hA5A5_0F0F);

        // R3/R4: outputs and mixed readback
        wr(5'h00, 32'hFFFF_0000);
        wr(5'h04, 32'h1234_5678);
        rd_lit("R4 data mixed", 5'h04, 32'h1234_0F0F);
        rd("R2 dir", 5'h00);

        // R6: polarity high, clear stale status
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'h0000_0000);
        tick(1);
        rd("R6 stat high", 5'h0C);
        check("R6 bit0 set", bus_rdata & 32'h1, 32'h1);

        // R7: ack while still active, re-set one edge later
        wr(5'h0C, 32'hFFFF_FFFE);
        rd_lit("R7 cleared", 5'h0C, bus_rdata & 32'hFFFF_FFFE);
        check("R7 bit0 clear", bus_rdata & 32'h1, 32'h0);
        tick(1);
        rd("R7 reset", 5'h0C);
        check("R7 bit0 back", bus_rdata & 32'h1, 32'h1);

        // R6: latching after level drops (bit1)
        pin_in = 32'hA5A5_0F0D;
        tick(4);
        rd("R6 latched", 5'h0C);
        check("R6 bit1 held", bus_rdata & 32'h2, 32'h2);
        wr(5'h0C, 32'hFFFF_FFFD);
        tick(3);
        rd("R7 stays clear", 5'h0C);
        check("R7 bit1 gone", bus_rdata & 32'h2, 32'h0);

        // R8: pending mirrors status, writes ignored
        rd("R8 pend", 5'h10);
        wr(5'h10, 32'h0);
        rd("R8 pend write", 5'h10);

        // R9: masking
        wr(5'h18, 32'hFFFF_FFFE);
        check("R9 irq open", {31'b0, irq_out}, 32'h1);
        wr(5'h18, 32'hFFFF_FFFF);
        check("R9 irq closed", {31'b0, irq_out}, 32'h0);

        // R10/R2: unmapped and misaligned
        wr(5'h14, 32'h0); wr(5'h1C, 32'h0); wr(5'h01, 32'h0); wr(5'h1A, 32'h0);
        rd_lit("R10 unmapped", 5'h14, '0);
        rd_lit("R2 misaligned", 5'h02, '0);
        rd("R10 dir kept", 5'h00);
        rd("R10 mask kept", 5'h18);

        // random phase
        for (int k = 0; k < 600; k++) begin
            logic [4:0] a;
            a = 5'($urandom);
            if ($urandom % 3 == 0) a = {a[4:2], 2'b00};
            case ($urandom % 4)
                0: pin_in = $urandom;
                1: wr(a, $urandom | (($urandom % 2) ? 32'hFFFF_0000 : 32'h0));
                default: tick(1);
            endcase
            rd("R2 R4 R8 random read", a);
        end

        finish_run();
    end
endmodule